// File: doc/BRIEF.md
# Converter Auto-Shutdown Power Sequencer

This block decides when the core of a serial analog-to-digital converter and its on-chip voltage reference get power. It starts with both of them off. A match on the slave address wakes the converter core. The core goes back to sleep as soon as its conversion reports done. The two-wire bus logic is kept awake at all times, so the next address can always be recognised.

A strap input selects external or internal reference.

- **Internal reference:** the read/write flag of the address byte controls the reference.
  - A 1 keeps the reference powered between conversions.
  - A 0 turns it off once the current conversion ends.
  - If another address match arrives while that turn-off is still pending, the turn-off is cancelled.
- **Settling delay:** whenever the reference goes from off to on, a settling counter must run down before a conversion may start. The counter is loaded from a parameter counted in system clocks, nominally 12 ms worth.
- **External reference:** the flag has no effect and the reference enable is held low.

Top module: `adcPwrSeq`

## Requirements
- R1: While `rstN` is low, and on the first cycles after it rises, `coreEn`, `refEn` and `convStart` are 0.
- R2: An `addrMatch` pulse seen while `coreEn` is 0 sets `coreEn` to 1 on the next clock edge.
- R3: A `convDone` pulse during a conversion clears `coreEn` on the next clock edge.
- R4: In internal mode (`extRef`=0), a wake with `rwFlag`=1 leaves `refEn` at 1 after the conversion completes.
- R5: In internal mode, a wake with `rwFlag`=0 clears `refEn` on the same edge that clears `coreEn`.
- R6: While `extRef` is 1, `refEn` is 0 one cycle later and stays 0 whatever `rwFlag` is. `convStart` follows the wake by exactly one cycle.
- R7: When a wake turns the reference on from off, `refReady` rises and `convStart` is issued exactly `SETTLE_CYCLES`+1 cycles after the wake edge. When the reference is already on and settled, `convStart` comes one cycle after the wake edge.
- R8: An `addrMatch` that arrives while the core is awake cancels a pending reference turn-off, so `refEn` stays 1 after the conversion. It neither restarts nor ends the conversion.
- R9: `convStart` is a one-cycle pulse, issued once per wake.
- R10: `ifaceAwake` is 1 at all times, including during reset.
- R11: A `convDone` pulse while no conversion is running changes neither `coreEn` nor `refEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset |
| addrMatch | input | 1 | One-cycle pulse: own slave address recognised |
| rwFlag | input | 1 | Read/write bit of the matched address byte |
| extRef | input | 1 | Strap: 1 = external reference, 0 = internal reference |
| convDone | input | 1 | One-cycle pulse: conversion finished |
| coreEn | output | 1 | Power enable for the converter core |
| refEn | output | 1 | Power enable for the internal reference |
| refReady | output | 1 | Internal reference powered and settled |
| convStart | output | 1 | One-cycle pulse that starts a conversion |
| ifaceAwake | output | 1 | Two-wire interface enable, held on |

## Verification
Wakes are tried under the following patterns:
- **Reference cold:** gives the full settling latency, which separates a counter that is loaded correctly from one that is skipped or loaded with the wrong value.
- **Reference already on:** gives the one-cycle latency.
- **External reference:** gives the one-cycle latency and shows `rwFlag` has no effect.

Random sequences of `rwFlag`, strap and done-delay check that the reference is kept or dropped after each conversion. Directed cases add:
- an extra address match while the core is busy (the turn-off must be cancelled);
- a stray done pulse while the core is idle (it must be ignored).

// File: rtl/adcPwrSeqPkg.sv
package adcPwrSeqPkg;

  typedef enum logic [1:0] {
    PH_SLEEP = 2'd0,
    PH_WAIT  = 2'd1,
    PH_CONV  = 2'd2
  } phase_t;

  typedef struct packed {
    logic refOnReq;
    logic refOffReq;
  } refStrobe_t;

endpackage

// File: rtl/adcPwrCtrl.sv
module adcPwrCtrl
  import adcPwrSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrMatch,
  input  logic       rwFlag,
  input  logic       extRef,
  input  logic       convDone,
  input  logic       refReady,
  output refStrobe_t strobe,
  output logic       coreEn,
  output logic       convStart
);

  phase_t phase;
  logic   offPending;
  logic   startOk;

  assign startOk = extRef || refReady;
  assign coreEn  = (phase != PH_SLEEP);

  always_comb begin
    strobe = '0;
    if (phase == PH_SLEEP && addrMatch && !extRef)
      strobe.refOnReq = 1'b1;
    if (phase == PH_CONV && convDone && offPending && !addrMatch)
      strobe.refOffReq = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_SLEEP;
      offPending <= 1'b0;
      convStart  <= 1'b0;
    end else begin
      convStart <= 1'b0;
      unique case (phase)
        PH_SLEEP: begin
          if (addrMatch) begin
            phase      <= PH_WAIT;
            offPending <= !extRef && !rwFlag;
          end
        end
        PH_WAIT: begin
          if (addrMatch) offPending <= 1'b0;
          if (startOk) begin
            phase     <= PH_CONV;
            convStart <= 1'b1;
          end
        end
        PH_CONV: begin
          if (addrMatch) offPending <= 1'b0;
          if (convDone) begin
            phase      <= PH_SLEEP;
            offPending <= 1'b0;
          end
        end
        default: phase <= PH_SLEEP;
      endcase
    end
  end

endmodule

// File: rtl/adcRefSettle.sv
module adcRefSettle
  import adcPwrSeqPkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 1_200_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extRef,
  input  refStrobe_t strobe,
  output logic       refEn,
  output logic       refReady
);

  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1) + 1;
  localparam logic [CW-1:0] LOADV = CW'(SETTLE_CYCLES);

  logic [CW-1:0] settleCnt;

  assign refReady = refEn && (settleCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refEn     <= 1'b0;
      settleCnt <= '0;
    end else if (extRef || strobe.refOffReq) begin
      refEn     <= 1'b0;
      settleCnt <= '0;
    end else if (strobe.refOnReq && !refEn) begin
      refEn     <= 1'b1;
      settleCnt <= LOADV;
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

endmodule

// File: rtl/adcPwrSeq.sv
module adcPwrSeq
  import adcPwrSeqPkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 1_200_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic addrMatch,
  input  logic rwFlag,
  input  logic extRef,
  input  logic convDone,
  output logic coreEn,
  output logic refEn,
  output logic refReady,
  output logic convStart,
  output logic ifaceAwake
);

  refStrobe_t strobe;

  assign ifaceAwake = 1'b1;

  adcPwrCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrMatch (addrMatch),
    .rwFlag    (rwFlag),
    .extRef    (extRef),
    .convDone  (convDone),
    .refReady  (refReady),
    .strobe    (strobe),
    .coreEn    (coreEn),
    .convStart (convStart)
  );

  adcRefSettle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ref (
    .clk      (clk),
    .rstN     (rstN),
    .extRef   (extRef),
    .strobe   (strobe),
    .refEn    (refEn),
    .refReady (refReady)
  );

endmodule

// File: rtl/adcPwrSeqChk.sv
module adcPwrSeqChk (
  input logic clk,
  input logic rstN,
  input logic addrMatch,
  input logic extRef,
  input logic coreEn,
  input logic refEn,
  input logic refReady,
  input logic convStart
);

  AST_RESET_OFF: assert property (@(posedge clk) !rstN |=> (!coreEn && !refEn && !convStart)); // R1

  AST_WAKE_CORE: assert property (@(posedge clk) disable iff (!rstN)
    (addrMatch && !coreEn) |=> coreEn); // R2

  AST_EXT_REF_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (extRef && $past(extRef) && $past(rstN)) |-> !refEn); // R6

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R9

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStart) |-> ($past(extRef) || $past(refReady))); // R7

  AST_START_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> coreEn); // R9

endmodule

bind adcPwrSeq adcPwrSeqChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addrMatch (addrMatch),
  .extRef    (extRef),
  .coreEn    (coreEn),
  .refEn     (refEn),
  .refReady  (refReady),
  .convStart (convStart)
);

// File: tb/adcPwrSeq_test.sv
`timescale 1ns/1ps
module adcPwrSeq_test;

  localparam int unsigned SETTLE = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrMatch = 1'b0, rwFlag = 1'b0, extRef = 1'b0, convDone = 1'b0;
  logic coreEn, refEn, refReady, convStart, ifaceAwake;

  int total = 0;
  int bad = 0;
  bit refOnModel = 1'b0;

  always #2.5 clk = ~clk;

  adcPwrSeq #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rstN(rstN), .addrMatch(addrMatch), .rwFlag(rwFlag),
    .extRef(extRef), .convDone(convDone), .coreEn(coreEn), .refEn(refEn),
    .refReady(refReady), .convStart(convStart), .ifaceAwake(ifaceAwake)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLatency(input bit ext, input bit refOn);
    return (ext || refOn) ? 1 : SETTLE + 1;
  endfunction

  function automatic bit expRefAfter(input bit ext, input bit rw, input bit cancelled);
    if (ext) return 1'b0;
    return rw || cancelled;
  endfunction

  task automatic wakeAndStart(input bit rw, output int lat);
    @(negedge clk);
    rwFlag = rw; addrMatch = 1'b1;
    @(negedge clk);
    addrMatch = 1'b0;
    check("R2 coreEn after wake", coreEn, 1);
    lat = 0;
    while (!convStart && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic finishConv(input int gap);
    for (int i = 0; i < gap; i++) @(negedge clk);
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
    check("R3 coreEn after done", coreEn, 0);
  endtask

  task automatic oneWake(input bit ext, input bit rw, input int gap, input bit cancel);
    int lat;
    if (extRef != ext) begin
      @(negedge clk);
      extRef = ext;
      @(negedge clk);
      if (ext) refOnModel = 1'b0;
    end
    wakeAndStart(rw, lat);
    check(ext ? "R6 start latency" : "R7 start latency", lat, expLatency(ext, refOnModel));
    if (!ext) check("R7 refReady at start", refReady, 1);
    @(negedge clk);
    check("R9 start pulse width", convStart, 0);
    if (ext) check("R6 refEn held off", refEn, 0);
    if (cancel) begin
      rwFlag = $urandom_range(0, 1); addrMatch = 1'b1;
      @(negedge clk);
      addrMatch = 1'b0;
      check("R8 core stays awake", coreEn, 1);
      check("R8 no restart", convStart, 0);
    end
    finishConv(gap);
    refOnModel = expRefAfter(ext, rw, cancel);
    check(ext ? "R6 refEn after done" : (rw || cancel ? (cancel ? "R8 refEn kept" : "R4 refEn kept")
          : "R5 refEn dropped"), refEn, refOnModel);
    check("R10 interface awake", ifaceAwake, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1 coreEn in reset", coreEn, 0);
    check("R1 refEn in reset", refEn, 0);
    check("R1 convStart in reset", convStart, 0);
    check("R10 interface awake in reset", ifaceAwake, 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 coreEn after reset", coreEn, 0);
    check("R1 refEn after reset", refEn, 0);

    // R11: stray done while idle
    convDone = 1'b1; @(negedge clk); convDone = 1'b0; @(negedge clk);
    check("R11 coreEn idle done", coreEn, 0);
    check("R11 refEn idle done", refEn, 0);

    // directed: cold internal keep, warm, drop, cancel, external
    oneWake(1'b0, 1'b1, 2, 1'b0);   // R4 cold
    oneWake(1'b0, 1'b0, 0, 1'b0);   // R7 warm, R5 drop
    oneWake(1'b0, 1'b0, 3, 1'b1);   // R8 cancel
    convDone = 1'b1; @(negedge clk); convDone = 1'b0; @(negedge clk);
    check("R11 refEn kept on idle done", refEn, 1);
    check("R11 coreEn idle done warm", coreEn, 0);
    oneWake(1'b1, 1'b0, 1, 1'b0);   // R6
    oneWake(1'b1, 1'b1, 1, 1'b0);   // R6 rw ignored

    for (int n = 0; n < 60; n++) begin
      oneWake(($urandom_range(0, 3) == 0), $urandom_range(0, 1),
              $urandom_range(0, 5), ($urandom_range(0, 4) == 0));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule